// File: doc/BRIEF.md
# Offset/Width Bitfield Operation Unit

This block is a bitfield arithmetic unit for a scalar integer datapath. Every operation is steered by one packed field specification that carries a bit offset and a field width. From one operand it can pull a field down to bit 0 with sign or zero fill, or build a positioned field with zeros everywhere else. It can also force a field to all ones or all zeros while the other bits pass through. The field specification comes either from an immediate or from the low bits of a second register.

A full field insert is built from three steps. First a make step positions the source field. Then a clear step on the old destination value opens the hole. An ordinary OR elsewhere in the pipeline merges the two. Each step reads at most two values and writes one. The result, a range flag and a valid bit are registered, so they appear one clock after the request.

Top module: `bitfield_unit`

## Requirements
- R1: The field specification is 2*FW bits wide, where FW = log2(XLEN). The field width sits in bits FW-1:0 and the offset in bits 2*FW-1:FW. With XLEN=64 this is width in bits 5:0 and offset in bits 11:6, so 0x04A means offset 1 and width 10. When `req_spec_sel` is 1 the specification is taken from the low bits of `req_spec_reg`, and when it is 0 from `req_spec_imm`.
- R2: Opcode values are 0 signed extract, 1 unsigned extract, 2 make, 3 set field and 4 clear field. Opcodes 5 to 7 give a zero result.
- R3: Signed extract returns the field starting at the offset, moved down to bit 0, with every higher bit a copy of the field's top bit.
- R4: Unsigned extract returns the same field with every higher bit zero.
- R5: Make takes the low width bits of the operand and shifts them left by the offset. Every bit outside the field is zero.
- R6: Set field forces every bit of the field to one. Every other bit equals the operand.
- R7: Clear field forces every bit of the field to zero. Every other bit equals the operand.
- R8: A width code of 0 selects a field of XLEN bits.
- R9: When offset plus effective width exceeds XLEN, the field stops at bit XLEN-1 and `res_range` is 1. Otherwise `res_range` is 0.
- R10: `res_valid` equals `req_valid` of the previous cycle. `res_data` and `res_range` reflect the request of the previous cycle, and they keep their value across cycles with `req_valid` low.
- R11: While reset is active, and in the first cycle after it, `res_valid`, `res_data` and `res_range` are zero.
- R12: With XLEN=32 the offset and width fields are 5 bits each, in a 10-bit specification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code |
| req_src | input | XLEN | Operand value |
| req_spec_imm | input | 2*FW | Immediate field specification |
| req_spec_reg | input | XLEN | Register carrying the specification in its low bits |
| req_spec_sel | input | 1 | 1 selects the register specification |
| res_valid | output | 1 | Result valid |
| res_data | output | XLEN | Result value |
| res_range | output | 1 | Field ran past the top bit |

## Verification
The bench builds two instances. One uses the default XLEN=64, with 6-bit offset and width codes. The other uses XLEN=32, so that the narrower 5-bit packing and truncation at bit 31 are exercised. At 64 bits the offset can reach 63 and the width code 0 means a full 64-bit field. These settings reach every edge case: single-bit fields at the top bit, fields that run far past the top, and the full-width field at offset zero.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  typedef enum logic [2:0] {
    BF_EXTS = 3'd0,
    BF_EXTU = 3'd1,
    BF_MAKE = 3'd2,
    BF_SETF = 3'd3,
    BF_CLRF = 3'd4
  } bf_op_e;
endpackage

// File: rtl/bfu_spec_decode.sv
module bfu_spec_decode #(
  parameter int XLEN = 64,
  localparam int FW = $clog2(XLEN),
  localparam int SPEC_W = 2 * FW
) (
  input  logic [SPEC_W-1:0] spec_imm,
  input  logic [XLEN-1:0]   spec_reg,
  input  logic              spec_sel,
  output logic [FW-1:0]     fld_off,
  output logic [FW:0]       fld_width,
  output logic [FW:0]       fld_kept,
  output logic              out_of_range
);
  localparam logic [FW:0] FULL = (FW+1)'(XLEN);

  logic [SPEC_W-1:0] spec;
  logic [FW-1:0]     wcode;
  logic [FW:0]       room;

  assign spec      = spec_sel ? spec_reg[SPEC_W-1:0] : spec_imm;
  assign wcode     = spec[FW-1:0];
  assign fld_off   = spec[SPEC_W-1:FW];
  assign fld_width = (wcode == '0) ? FULL : {1'b0, wcode};
  assign room      = FULL - {1'b0, fld_off};

  assign out_of_range = fld_width > room;
  assign fld_kept     = out_of_range ? room : fld_width;
endmodule

// File: rtl/bfu_mask_gen.sv
module bfu_mask_gen #(
  parameter int XLEN = 64,
  localparam int FW = $clog2(XLEN)
) (
  input  logic [FW-1:0]   fld_off,
  input  logic [FW:0]     fld_width,
  input  logic [FW:0]     fld_kept,
  output logic [XLEN-1:0] low_width,
  output logic [XLEN-1:0] low_kept,
  output logic [XLEN-1:0] fld_mask
);
  function automatic logic [XLEN-1:0] ones_below(input logic [FW:0] n);
    ones_below = ~({XLEN{1'b1}} << n);
  endfunction

  assign low_width = ones_below(fld_width);
  assign low_kept  = ones_below(fld_kept);
  assign fld_mask  = low_width << fld_off;
endmodule

// File: rtl/bfu_datapath.sv
module bfu_datapath
  import bfu_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int FW = $clog2(XLEN)
) (
  input  bf_op_e          op,
  input  logic [XLEN-1:0] src,
  input  logic [FW-1:0]   fld_off,
  input  logic [XLEN-1:0] low_width,
  input  logic [XLEN-1:0] low_kept,
  input  logic [XLEN-1:0] fld_mask,
  output logic [XLEN-1:0] result
);
  logic [XLEN-1:0] shifted, top_bit, ext_u, ext_s, made;
  logic            neg;

  assign shifted = src >> fld_off;
  assign ext_u   = shifted & low_kept;
  assign top_bit = low_kept & ~(low_kept >> 1);
  assign neg     = |(shifted & top_bit);
  assign ext_s   = neg ? (shifted | ~low_kept) : ext_u;
  assign made    = (src & low_width) << fld_off;

  always_comb begin
    unique case (op)
      BF_EXTS: result = ext_s;
      BF_EXTU: result = ext_u;
      BF_MAKE: result = made;
      BF_SETF: result = src | fld_mask;
      BF_CLRF: result = src & ~fld_mask;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bfu_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int FW = $clog2(XLEN),
  localparam int SPEC_W = 2 * FW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [XLEN-1:0]   req_src,
  input  logic [SPEC_W-1:0] req_spec_imm,
  input  logic [XLEN-1:0]   req_spec_reg,
  input  logic              req_spec_sel,
  output logic              res_valid,
  output logic [XLEN-1:0]   res_data,
  output logic              res_range
);
  bf_op_e          op;
  logic [FW-1:0]   fld_off;
  logic [FW:0]     fld_width, fld_kept;
  logic            oor;
  logic [XLEN-1:0] low_width, low_kept, fld_mask, dp_result;

  assign op = bf_op_e'(req_op);

  bfu_spec_decode #(.XLEN(XLEN)) u_dec (
    .spec_imm(req_spec_imm), .spec_reg(req_spec_reg), .spec_sel(req_spec_sel),
    .fld_off(fld_off), .fld_width(fld_width), .fld_kept(fld_kept),
    .out_of_range(oor)
  );

  bfu_mask_gen #(.XLEN(XLEN)) u_mask (
    .fld_off(fld_off), .fld_width(fld_width), .fld_kept(fld_kept),
    .low_width(low_width), .low_kept(low_kept), .fld_mask(fld_mask)
  );

  bfu_datapath #(.XLEN(XLEN)) u_dp (
    .op(op), .src(req_src), .fld_off(fld_off), .low_width(low_width),
    .low_kept(low_kept), .fld_mask(fld_mask), .result(dp_result)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_range <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_data  <= dp_result;
        res_range <= oor;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid); // R10
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(res_data) && $stable(res_range)); // R10
  AST_MAKE_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == BF_MAKE) |-> ((dp_result & ~fld_mask) == '0)); // R5
  AST_SET_FIELD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == BF_SETF) |-> ((dp_result & fld_mask) == fld_mask)); // R6
  AST_CLR_FIELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == BF_CLRF) |-> ((dp_result & fld_mask) == '0)); // R7
  AST_SETCLR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (op == BF_SETF || op == BF_CLRF))
      |-> (((dp_result ^ req_src) & ~fld_mask) == '0)); // R6
  AST_EXTU_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == BF_EXTU) |-> ((dp_result & ~low_kept) == '0)); // R4
  AST_RANGE_REACHES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && oor) |-> fld_mask[XLEN-1]); // R9
endmodule

// File: tb/bitfield_unit_tb_top.sv
module bitfield_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        v64, ss64, rv64, rr64;
  logic [2:0]  op64;
  logic [63:0] src64, sreg64, rd64;
  logic [11:0] simm64;

  logic        v32, ss32, rv32, rr32;
  logic [2:0]  op32;
  logic [31:0] src32, sreg32, rd32;
  logic [9:0]  simm32;

  bitfield_unit #(.XLEN(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(v64), .req_op(op64), .req_src(src64),
    .req_spec_imm(simm64), .req_spec_reg(sreg64), .req_spec_sel(ss64),
    .res_valid(rv64), .res_data(rd64), .res_range(rr64)
  );

  bitfield_unit #(.XLEN(32)) dut32_i (
    .clk(clk), .rst_n(rst_n), .req_valid(v32), .req_op(op32), .req_src(src32),
    .req_spec_imm(simm32), .req_spec_reg(sreg32), .req_spec_sel(ss32),
    .res_valid(rv32), .res_data(rd32), .res_range(rr32)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bit-by-bit reference: n = data width, op code, offset, width code.
  function automatic logic [63:0] ref_calc(input int n, input int op, input logic [63:0] s,
                                           input int off, input int w, output bit rng);
    int ew, tw;
    logic [63:0] r;
    ew = (w == 0) ? n : w;
    rng = (off + ew) > n;
    tw = rng ? n - off : ew;
    r = '0;
    for (int i = 0; i < n; i++) begin
      case (op)
        0, 1: begin
          if (i < tw) r[i] = s[off+i];
          else if (op == 0) r[i] = s[off+tw-1];
        end
        2: if (i >= off && i < off + ew) r[i] = s[i-off];
        3: r[i] = (i >= off && i < off + ew) ? 1'b1 : s[i];
        4: r[i] = (i >= off && i < off + ew) ? 1'b0 : s[i];
        default: r[i] = 1'b0;
      endcase
    end
    return r;
  endfunction

  task automatic run64(input string tag, input int op, input logic [63:0] s,
                       input int off, input int w, input bit from_reg);
    logic [11:0] spec;
    logic [63:0] e;
    bit rng;
    spec = {off[5:0], w[5:0]};
    @(negedge clk);
    v64 = 1'b1; op64 = op[2:0]; src64 = s; ss64 = from_reg;
    simm64 = from_reg ? ~spec : spec;
    sreg64 = from_reg ? {52'hABCDE_F0123_456, spec} : 64'h0;
    @(posedge clk);
    @(negedge clk);
    v64 = 1'b0;
    e = ref_calc(64, op, s, off, w, rng);
    chk({tag, " data"}, rd64, e);
    chk({tag, " range"}, {63'd0, rr64}, {63'd0, rng});
    chk({tag, " valid R10"}, {63'd0, rv64}, 64'd1);
  endtask

  task automatic run32(input string tag, input int op, input logic [31:0] s,
                       input int off, input int w);
    logic [63:0] e;
    bit rng;
    @(negedge clk);
    v32 = 1'b1; op32 = op[2:0]; src32 = s; ss32 = 1'b0;
    simm32 = {off[4:0], w[4:0]}; sreg32 = '0;
    @(posedge clk);
    @(negedge clk);
    v32 = 1'b0;
    e = ref_calc(32, op, {32'd0, s}, off, w, rng);
    chk({tag, " data R12"}, {32'd0, rd32}, e);
    chk({tag, " range R12"}, {63'd0, rr32}, {63'd0, rng});
  endtask

  task automatic t_reset;
    chk("R11 valid in reset", {63'd0, rv64}, 64'd0);
    chk("R11 data in reset", rd64, 64'd0);
    chk("R11 range in reset", {63'd0, rr64}, 64'd0);
  endtask

  task automatic t_spec_source;
    run64("R1 imm spec", 1, 64'hFEDC_BA98_7654_3210, 8, 12, 1'b0);
    run64("R1 reg spec", 1, 64'hFEDC_BA98_7654_3210, 20, 7, 1'b1);
    run64("R1 packing 0x04A", 2, 64'h0000_0000_0000_03FF, 1, 10, 1'b0);
    chk("R1 0x04A gives bits 10:1", rd64, 64'h0000_0000_0000_07FE);
  endtask

  task automatic t_extract;
    run64("R3 exts neg", 0, 64'h0000_0000_00F0_0000, 20, 4, 1'b0);
    chk("R3 exts all ones", rd64, 64'hFFFF_FFFF_FFFF_FFFF);
    run64("R3 exts pos", 0, 64'h0000_0000_0070_0000, 20, 4, 1'b0);
    run64("R3 exts top bit", 0, 64'h8000_0000_0000_0000, 63, 1, 1'b1);
    run64("R4 extu", 1, 64'hDEAD_BEEF_CAFE_F00D, 21, 10, 1'b0);
    run64("R4 extu neg field", 1, 64'hFFFF_FFFF_FFFF_FFFF, 5, 17, 1'b0);
  endtask

  task automatic t_make_insert;
    logic [63:0] made, cleared;
    run64("R5 make", 2, 64'hFFFF_FFFF_FFFF_FFFF, 40, 9, 1'b0);
    run64("R5 insert make", 2, 64'h0000_0000_0000_02A5, 1, 10, 1'b0);
    made = rd64;
    run64("R7 insert clear", 4, 64'hFFFF_FFFF_FFFF_FFFF, 1, 10, 1'b0);
    cleared = rd64;
    chk("R5 insert or-merge", made | cleared, 64'hFFFF_FFFF_FFFF_FD4B);
  endtask

  task automatic t_set_clr;
    run64("R6 set", 3, 64'h1234_5678_9ABC_DEF0, 12, 16, 1'b0);
    run64("R6 set single", 3, 64'h0, 0, 1, 1'b1);
    run64("R7 clear", 4, 64'h1234_5678_9ABC_DEF0, 30, 20, 1'b0);
  endtask

  task automatic t_width_zero;
    run64("R8 extu full", 1, 64'h8765_4321_0FED_CBA9, 0, 0, 1'b0);
    chk("R8 full passthrough", rd64, 64'h8765_4321_0FED_CBA9);
    run64("R8 clear full", 4, 64'hFFFF_0000_FFFF_0000, 0, 0, 1'b0);
    chk("R8 clear full zero", rd64, 64'h0);
  endtask

  task automatic t_range;
    run64("R9 exts overrun", 0, 64'hC000_0000_0000_0000, 60, 10, 1'b0);
    run64("R9 make overrun", 2, 64'hFFFF_FFFF_FFFF_FFFF, 50, 30, 1'b0);
    run64("R9 set overrun", 3, 64'h0, 63, 0, 1'b0);
    run64("R9 exact fit", 1, 64'hF000_0000_0000_0000, 60, 4, 1'b0);
  endtask

  task automatic t_latency_hold;
    logic [63:0] held;
    run64("R10 setup", 1, 64'h0000_0000_0000_ABCD, 4, 8, 1'b0);
    held = rd64;
    @(negedge clk);
    op64 = 3'd3; src64 = 64'hFFFF; simm64 = 12'h000;
    @(negedge clk);
    chk("R10 valid low when idle", {63'd0, rv64}, 64'd0);
    chk("R10 data held when idle", rd64, held);
  endtask

  task automatic t_bad_op;
    run64("R2 op5 zero", 5, 64'hFFFF_FFFF_FFFF_FFFF, 0, 8, 1'b0);
    run64("R2 op7 zero", 7, 64'h1234, 3, 3, 1'b0);
  endtask

  task automatic t_narrow;
    run32("R12 extu", 1, 32'hDEAD_BEEF, 4, 12);
    run32("R12 exts", 0, 32'h8000_0000, 28, 4);
    run32("R12 full", 4, 32'hFFFF_FFFF, 0, 0);
    run32("R12 overrun", 3, 32'h0, 30, 6);
  endtask

  initial begin
    v64 = 0; op64 = 0; src64 = 0; simm64 = 0; sreg64 = 0; ss64 = 0;
    v32 = 0; op32 = 0; src32 = 0; simm32 = 0; sreg32 = 0; ss32 = 0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 valid after reset", {63'd0, rv64}, 64'd0);
    t_spec_source;
    t_extract;
    t_make_insert;
    t_set_clr;
    t_width_zero;
    t_range;
    t_latency_hold;
    t_bad_op;
    t_narrow;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule